// File: doc/BRIEF.md
# Fiber Far-End-Fault Idle Generator and Detector

This block lets a 100 Mbps fiber port report a local receive fault to the far end, and notice when the far end reports one back. Fiber links have no negotiation handshake that could carry such a fault. So the fault is coded into the idle bit stream. Healthy idle is a steady run of ones. Fault idle is a fixed run of ones cut by one zero, repeated for as long as idle lasts.

On the transmit side the block produces the idle bit, one bit per asserted bit enable. It emits the fault code only when four things hold together: the fiber path is on, the fault feature is selected, the transmitter is idle, and no signal is detected on the receive side. On the receive side it counts runs of ones in the incoming serial bits. A run of exactly the code length followed by a zero is one matching interval. After a set number of back-to-back matches the block raises a live LED output and a sticky remote-fault status bit. The status bit clears on a status read, but only once the fault stream has gone away.

Top module: `ffault_top`

## Requirements
- R1: After synchronous reset, `idle_bit` is 1, `remote_fault` is 0 and `fault_led` is 0.
- R2: While fiber and fault select are on, `tx_idle` is 1 and `sig_det` is 0, `idle_bit` follows a cycle of 85 enabled bits: 84 ones, then one zero. The cycle repeats.
- R3: If any of those four conditions is false, every enabled bit drives `idle_bit` to 1.
- R4: Each time the generator condition begins again, the pattern restarts. The first 84 enabled bits are ones and the 85th is the zero.
- R5: A cycle with `bit_en` low advances neither side. `idle_bit` holds its value, and `rx_bit` is ignored.
- R6: `fault_led` and `remote_fault` rise one clock after the bit enable that takes in the zero ending the third back-to-back matching interval. After only two intervals they stay low.
- R7: A zero that ends a run of ones other than exactly 84 sets the back-to-back match count to zero.
- R8: Once 85 ones arrive in a row, the fault condition is gone. `fault_led` falls one clock after the bit enable that takes in the 85th one.
- R9: `remote_fault` stays 1 after the condition ends. A one-cycle `stat_rd` pulse clears it one clock later, but only if the condition is no longer present. A read while the condition is present leaves it at 1.
- R10: While `fiber_en` or `fef_sel` is 0, the receive match count is held at zero. `fault_led` then falls within two clocks, and matching intervals raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle enable per serial bit time |
| fiber_en | input | 1 | Fiber path enabled |
| fef_sel | input | 1 | Configuration select for the far-end-fault feature |
| tx_idle | input | 1 | Transmitter is sending idle |
| sig_det | input | 1 | Receive signal detected |
| rx_bit | input | 1 | Received serial bit |
| stat_rd | input | 1 | Status read pulse, clears the sticky bit when allowed |
| idle_bit | output | 1 | Idle bit to transmit, registered |
| remote_fault | output | 1 | Sticky remote-fault status |
| fault_led | output | 1 | Live fault indicator, registered |

## Verification
Suppose the transmit counter loses its place or fails to restart. Then the zero shows up at `idle_bit` at a position other than the 85th enabled bit, so counting enables from the point where the condition begins exposes it within one pattern period. Suppose the receive run counter or match count goes wrong. Then `fault_led` rises one interval early or late, or fails to fall on the 85th one, and the bench samples it exactly one clock after the deciding bit. A sticky-bit error shows up as the wrong `remote_fault` value in the clock right after a `stat_rd` pulse.

// File: rtl/ffault_pkg.sv
package ffault_pkg;
  localparam int unsigned FF_RUN_DEF     = 84;
  localparam int unsigned FF_CONFIRM_DEF = 3;

  function automatic int unsigned ff_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/ffault_txgen.sv
module ffault_txgen #(
  parameter int unsigned RUN_LEN = ffault_pkg::FF_RUN_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic gen_on,
  output logic bit_o
);
  localparam int unsigned CW = ffault_pkg::ff_bits(RUN_LEN);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN);

  logic [CW-1:0] pos_q;
  logic          bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      bit_q <= 1'b1;
    end else if (bit_en) begin
      if (!gen_on) begin
        pos_q <= '0;
        bit_q <= 1'b1;
      end else if (pos_q == LAST) begin
        pos_q <= '0;
        bit_q <= 1'b0;
      end else begin
        pos_q <= pos_q + CW'(1);
        bit_q <= 1'b1;
      end
    end
  end

  assign bit_o = bit_q;

  // a zero never lasts longer than one enabled bit
  assert_single_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!bit_o && bit_en) |=> bit_o);
  // generator off forces ones
  assert_ones_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !gen_on) |=> bit_o);
  // no advance without a bit enable
  assert_hold_tx_R5: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(bit_o));
endmodule

// File: rtl/ffault_rxdet.sv
module ffault_rxdet #(
  parameter int unsigned RUN_LEN = ffault_pkg::FF_RUN_DEF,
  parameter int unsigned CONFIRM = ffault_pkg::FF_CONFIRM_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic active,
  input  logic rx_bit,
  output logic det_o
);
  localparam int unsigned RW = ffault_pkg::ff_bits(RUN_LEN + 1);
  localparam int unsigned HW = ffault_pkg::ff_bits(CONFIRM);
  localparam logic [RW-1:0] RUN_EXACT = RW'(RUN_LEN);
  localparam logic [RW-1:0] RUN_OVER  = RW'(RUN_LEN + 1);
  localparam logic [HW-1:0] HIT_MAX   = HW'(CONFIRM);

  logic [RW-1:0] run_q;
  logic [HW-1:0] hits_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      run_q  <= '0;
      hits_q <= '0;
    end else if (bit_en) begin
      if (rx_bit) begin
        if (run_q == RUN_EXACT) begin
          run_q  <= RUN_OVER;
          hits_q <= '0;
        end else if (run_q != RUN_OVER) begin
          run_q <= run_q + RW'(1);
        end
      end else begin
        run_q <= '0;
        if (run_q == RUN_EXACT) begin
          if (hits_q != HIT_MAX) hits_q <= hits_q + HW'(1);
        end else begin
          hits_q <= '0;
        end
      end
    end
  end

  assign det_o = (hits_q == HIT_MAX);

  // an inactive feature holds the match count at zero
  assert_clear_inactive_R10: assert property (@(posedge clk) disable iff (rst)
    !active |=> (hits_q == '0));
  // no bit enable, no change in match count
  assert_hold_rx_R5: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && active) |=> $stable(hits_q));
  // a zero after a wrong run length empties the count
  assert_bad_run_R7: assert property (@(posedge clk) disable iff (rst)
    (active && bit_en && !rx_bit && run_q != RUN_EXACT) |=> (hits_q == '0));
endmodule

// File: rtl/ffault_stat.sv
module ffault_stat (
  input  logic clk,
  input  logic rst,
  input  logic det,
  input  logic rd,
  output logic sticky_o,
  output logic led_o
);
  logic sticky_q;
  logic led_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= 1'b0;
      led_q    <= 1'b0;
    end else begin
      led_q    <= det;
      sticky_q <= det | (sticky_q & ~rd);
    end
  end

  assign sticky_o = sticky_q;
  assign led_o    = led_q;

  // detection sets both outputs
  assert_set_on_detect_R6: assert property (@(posedge clk) disable iff (rst)
    det |=> (sticky_o && led_o));
  // status holds without a read
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (sticky_o && !rd) |=> sticky_o);
endmodule

// File: rtl/ffault_top.sv
module ffault_top #(
  parameter int unsigned RUN_LEN = ffault_pkg::FF_RUN_DEF,
  parameter int unsigned CONFIRM = ffault_pkg::FF_CONFIRM_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic fiber_en,
  input  logic fef_sel,
  input  logic tx_idle,
  input  logic sig_det,
  input  logic rx_bit,
  input  logic stat_rd,
  output logic idle_bit,
  output logic remote_fault,
  output logic fault_led
);
  logic active;
  logic gen_on;
  logic det;

  assign active = fiber_en & fef_sel;
  assign gen_on = active & tx_idle & ~sig_det;

  ffault_txgen #(.RUN_LEN(RUN_LEN)) u_tx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .gen_on(gen_on), .bit_o(idle_bit)
  );

  ffault_rxdet #(.RUN_LEN(RUN_LEN), .CONFIRM(CONFIRM)) u_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .active(active),
    .rx_bit(rx_bit), .det_o(det)
  );

  ffault_stat u_st (
    .clk(clk), .rst(rst), .det(det), .rd(stat_rd),
    .sticky_o(remote_fault), .led_o(fault_led)
  );

  // reset leaves the outputs quiet
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (idle_bit && !remote_fault && !fault_led));
endmodule

// File: tb/sim_ffault_top.sv
module sim_ffault_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, fiber_en = 1'b1, fef_sel = 1'b1, tx_idle = 1'b0;
  logic sig_det = 1'b0, rx_bit = 1'b1, stat_rd = 1'b0;
  logic idle_bit, remote_fault, fault_led;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ffault_top u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .fiber_en(fiber_en), .fef_sel(fef_sel),
    .tx_idle(tx_idle), .sig_det(sig_det), .rx_bit(rx_bit), .stat_rd(stat_rd),
    .idle_bit(idle_bit), .remote_fault(remote_fault), .fault_led(fault_led)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; fiber_en = 1'b1; fef_sel = 1'b1;
    tx_idle = 1'b0; sig_det = 1'b0; rx_bit = 1'b1; stat_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tx_step(output logic b);
    @(negedge clk); bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    b = idle_bit;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_run(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
    send_bit(1'b0);
  endtask

  task automatic read_pulse();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 idle_bit", idle_bit, 1);
    chk("R1 remote_fault", remote_fault, 0);
    chk("R1 fault_led", fault_led, 0);
  endtask

  task automatic t_tx_pattern();
    int bad;
    logic b;
    do_reset();
    tx_idle = 1'b1;
    for (int p = 0; p < 2; p++) begin
      bad = 0;
      for (int i = 1; i <= 85; i++) begin
        tx_step(b);
        if (b != ((i == 85) ? 1'b0 : 1'b1)) bad++;
      end
      chk("R2 pattern period mismatches", bad, 0);
    end
  endtask

  task automatic t_tx_off();
    int zeros;
    logic b;
    for (int m = 0; m < 4; m++) begin
      do_reset();
      tx_idle = (m != 0); fef_sel = (m != 1); fiber_en = (m != 2); sig_det = (m == 3);
      zeros = 0;
      for (int i = 0; i < 180; i++) begin
        tx_step(b);
        if (!b) zeros++;
      end
      chk($sformatf("R3 zeros with condition %0d off", m), zeros, 0);
    end
  endtask

  task automatic t_restart();
    int bad;
    logic b;
    do_reset();
    tx_idle = 1'b1;
    for (int i = 0; i < 40; i++) tx_step(b);
    tx_idle = 1'b0;
    tx_step(b);
    chk("R4 not idle gives one", b, 1);
    tx_idle = 1'b1;
    bad = 0;
    for (int i = 1; i <= 85; i++) begin
      tx_step(b);
      if (b != ((i == 85) ? 1'b0 : 1'b1)) bad++;
    end
    chk("R4 restart period mismatches", bad, 0);
  endtask

  task automatic t_gate();
    logic b;
    do_reset();
    tx_idle = 1'b1;
    for (int i = 0; i < 85; i++) tx_step(b);
    repeat (20) @(negedge clk);
    chk("R5 idle_bit held without enable", idle_bit, 0);
    tx_idle = 1'b0;
    do_reset();
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 84; i++) send_bit(1'b1);
      @(negedge clk); rx_bit = 1'b0;
      repeat (5) @(negedge clk);
      send_bit(1'b0);
    end
    @(negedge clk);
    chk("R5 ignored bits, fault_led", fault_led, 1);
  endtask

  task automatic t_detect();
    do_reset();
    send_run(84); send_run(84);
    repeat (2) @(negedge clk);
    chk("R6 two intervals, fault_led", fault_led, 0);
    send_run(84);
    chk("R6 led not before next clock", fault_led, 0);
    @(negedge clk);
    chk("R6 fault_led", fault_led, 1);
    chk("R6 remote_fault", remote_fault, 1);
  endtask

  task automatic t_badrun();
    do_reset();
    send_run(84); send_run(83); send_run(84); send_run(84);
    @(negedge clk);
    chk("R7 after short run, fault_led", fault_led, 0);
    send_run(84);
    @(negedge clk);
    chk("R7 third good after short run", fault_led, 1);
    do_reset();
    send_run(84); send_run(84); send_run(85); send_run(84); send_run(84);
    @(negedge clk);
    chk("R7 after long run, fault_led", fault_led, 0);
  endtask

  task automatic t_runout();
    do_reset();
    send_run(84); send_run(84); send_run(84);
    for (int i = 0; i < 84; i++) send_bit(1'b1);
    @(negedge clk);
    chk("R8 led kept after 84 ones", fault_led, 1);
    send_bit(1'b1);
    @(negedge clk);
    chk("R8 led falls after 85th one", fault_led, 0);
  endtask

  task automatic t_sticky();
    do_reset();
    send_run(84); send_run(84); send_run(84);
    @(negedge clk);
    read_pulse();
    chk("R9 read while present", remote_fault, 1);
    for (int i = 0; i < 85; i++) send_bit(1'b1);
    repeat (2) @(negedge clk);
    chk("R9 sticky after condition gone", remote_fault, 1);
    read_pulse();
    chk("R9 cleared by read", remote_fault, 0);
  endtask

  task automatic t_inactive();
    do_reset();
    fef_sel = 1'b0;
    send_run(84); send_run(84); send_run(84);
    repeat (2) @(negedge clk);
    chk("R10 select off, fault_led", fault_led, 0);
    chk("R10 select off, remote_fault", remote_fault, 0);
    do_reset();
    send_run(84); send_run(84); send_run(84);
    @(negedge clk);
    fiber_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 fiber off drops led", fault_led, 0);
    fiber_en = 1'b1;
    send_run(84);
    @(negedge clk);
    chk("R10 count restarted", fault_led, 0);
  endtask

  initial begin
    t_reset();
    t_tx_pattern();
    t_tx_off();
    t_restart();
    t_gate();
    t_detect();
    t_badrun();
    t_runout();
    t_sticky();
    t_inactive();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule